// File: doc/BRIEF.md
# Self-Programming Command Control Register

This block is the control and status register through which a small microcontroller core starts flash self-programming operations. Software writes a set of command bits together with an enable bit. That write arms the block for a short window. If the core executes the matching instruction inside that window (a store for erase, write, buffer fill and read-while-write re-enable, a load for signature and lock/fuse reads), the block sends one decoded command pulse to the flash controller. The pulse carries the Z-pointer split into a page number (upper bits) and an offset (lower bits). If no matching instruction arrives in time, the armed bits clear themselves and no pulse is sent.

A page erase or page write keeps its command bits set until the flash controller reports completion through its busy flag. The CPU is held halted for the whole page write. The block also clears the temporary page buffer when software writes the section read enable bit while buffer fill data is pending. It raises a ready interrupt when software has enabled it, the global interrupt flag is set, and neither a command nor an EEPROM write is in progress.

Top module: `selfprog_ctrl`

## Requirements
- R1: The read port returns, from bit 7 down to bit 0: interrupt enable, section busy, signature read, section read enable, lock-bit set, page write, page erase, enable. After reset it reads 0x00, and no command pulse, halt, buffer clear or interrupt is active.
- R2: Bit 6 always reads 0, whatever value is written to it.
- R3: A write with bit 0 set arms the block. The written bits are stored with bit 6 forced to 0, and they read back unchanged while armed. A write with bit 0 clear keeps only bit 7, clears bits 6..0 and cancels any open window.
- R4: Erase, page write, buffer fill (bit 0 alone) and section read enable are store-type commands. A store sampled on any of the 4 rising edges after the arming edge is accepted. If none arrives by the 4th edge, bits 5..0 clear on that edge and no pulse follows. A new arming write restarts the window from that write.
- R5: Signature read and lock-bit read are load-type commands with a 3-edge window. A load on the 4th edge is ignored, and bits 5..0 are already clear by then.
- R6: For an accepted erase or page write, `cmd_erase` or `cmd_write` pulses high for one cycle, starting one cycle after the accepting edge. `cmd_page` = Z[ZW-1:PG_LSB] and `cmd_offs` = Z[PG_LSB-1:0]. A load during a store-type window, or a store during a load-type window, is ignored and the window keeps running. Erase and page write bits stay set until completion, which is the first edge that samples `flash_busy` low after `flash_busy` has been sampled high. Bits 5..0 clear on that edge.
- R7: `cpu_halt` is high from the `cmd_write` pulse cycle until page write completion. It is not raised for an erase. A register write during a running erase or page write changes only bit 7.
- R8: An accepted buffer fill, signature read or lock-bit read pulses `cmd_fill`, `cmd_sig_rd` or `cmd_lock_rd` for one cycle, with Z captured as in R6. For a lock read, `cmd_offs[0]` selects the lock bits (0) or the fuse bits (1). Bits 5..0 clear on the accepting edge.
- R9: `buf_clear` pulses for one cycle after a register write with bit 4 set, but only while fill data is pending. Fill data becomes pending on a fill pulse and stops being pending after a completed page write or a buffer clear. Otherwise `buf_clear` stays low.
- R10: `ready_irq` equals bit 7 AND `gie` AND NOT bit 0 AND NOT `eeprom_busy` AND no erase or page write running.
- R11: When several command bits are armed together, the priority is erase, page write, signature read, lock-bit read, section read enable, buffer fill. At most one pulse is issued per armed window. Section read enable consumes its store with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data |
| st_exec | input | 1 | A store-program instruction executes this cycle |
| ld_exec | input | 1 | A load-program instruction executes this cycle |
| zptr | input | ZW | Z-pointer value |
| gie | input | 1 | Global interrupt flag |
| flash_busy | input | 1 | Flash controller busy |
| eeprom_busy | input | 1 | EEPROM write in progress |
| cmd_erase | output | 1 | Page erase command pulse |
| cmd_write | output | 1 | Page write command pulse |
| cmd_fill | output | 1 | Buffer fill command pulse |
| cmd_sig_rd | output | 1 | Signature read command pulse |
| cmd_lock_rd | output | 1 | Lock/fuse read command pulse |
| cmd_page | output | ZW-PG_LSB | Page number captured with the pulse |
| cmd_offs | output | PG_LSB | Offset captured with the pulse |
| cpu_halt | output | 1 | CPU halt request during page write |
| buf_clear | output | 1 | Temporary page buffer clear pulse |
| ready_irq | output | 1 | Self-programming ready interrupt |

## Verification
A wrong window count shows at the ports within five cycles of an arming write. Either a store or load at the window boundary gets or loses its command pulse, or the read-back of bits 5..0 disagrees with the expected armed or cleared value on the very next cycle. A stuck operation-running state shows as `cpu_halt` or a masked `ready_irq` that lasts past the edge after `flash_busy` falls. A wrong priority or a wrong Z capture shows in the one-cycle pulse itself. A scoreboard compares the kind, page and offset of that pulse in the cycle it appears, and any pulse with no matching expectation is reported at once.

// File: rtl/spm_cmd_pkg.sv
package spm_cmd_pkg;

  // register field positions (decoded by software and by this block)
  localparam int B_IRQ  = 7;
  localparam int B_BUSY = 6;
  localparam int B_SIG  = 5;
  localparam int B_RWW  = 4;
  localparam int B_LOCK = 3;
  localparam int B_PGW  = 2;
  localparam int B_PGE  = 1;
  localparam int B_EN   = 0;

  // command pulse positions
  localparam int NK      = 5;
  localparam int K_ERASE = 0;
  localparam int K_WRITE = 1;
  localparam int K_FILL  = 2;
  localparam int K_SIG   = 3;
  localparam int K_LOCK  = 4;

  typedef enum logic [2:0] {
    M_IDLE, M_ERASE, M_WRITE, M_SIG, M_LOCK, M_RWW, M_FILL
  } mode_e;

  // priority decode of the command field; c[0] is the enable bit
  function automatic mode_e decode_mode(input logic [5:0] c);
    mode_e m;
    if (!c[B_EN])        m = M_IDLE;
    else if (c[B_PGE])   m = M_ERASE;
    else if (c[B_PGW])   m = M_WRITE;
    else if (c[B_SIG])   m = M_SIG;
    else if (c[B_LOCK])  m = M_LOCK;
    else if (c[B_RWW])   m = M_RWW;
    else                 m = M_FILL;
    return m;
  endfunction

  function automatic logic is_read(input mode_e m);
    return (m == M_SIG) || (m == M_LOCK);
  endfunction

  function automatic logic is_flash_op(input mode_e m);
    return (m == M_ERASE) || (m == M_WRITE);
  endfunction

  function automatic int unsigned arm_len(input mode_e m, input int unsigned wr_n,
                                          input int unsigned rd_n);
    return is_read(m) ? rd_n : wr_n;
  endfunction

  function automatic logic [NK-1:0] cmd_onehot(input mode_e m);
    logic [NK-1:0] v;
    v = '0;
    case (m)
      M_ERASE: v[K_ERASE] = 1'b1;
      M_WRITE: v[K_WRITE] = 1'b1;
      M_FILL:  v[K_FILL]  = 1'b1;
      M_SIG:   v[K_SIG]   = 1'b1;
      M_LOCK:  v[K_LOCK]  = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/spm_window.sv
module spm_window #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          stop_i,
  output logic          open_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (stop_i)        cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/spm_issue.sv
module spm_issue
  import spm_cmd_pkg::*;
#(
  parameter int ZW     = 16,
  parameter int PG_LSB = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  mode_e            mode_i,
  input  logic [ZW-1:0]    zptr_i,
  output logic [NK-1:0]    pulse_o,
  output logic [ZW-PG_LSB-1:0] page_o,
  output logic [PG_LSB-1:0]    offs_o
);
  logic [NK-1:0] sel;
  assign sel = cmd_onehot(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o <= '0;
      page_o  <= '0;
      offs_o  <= '0;
    end else begin
      pulse_o <= fire_i ? sel : '0;
      if (fire_i) begin
        page_o <= zptr_i[ZW-1:PG_LSB];
        offs_o <= zptr_i[PG_LSB-1:0];
      end
    end
  end
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import spm_cmd_pkg::*;
#(
  parameter int ZW     = 16,
  parameter int PG_LSB = 7,
  parameter int WIN_WR = 4,
  parameter int WIN_RD = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [7:0]           reg_wr_data,
  output logic [7:0]           reg_rd_data,
  input  logic                 st_exec,
  input  logic                 ld_exec,
  input  logic [ZW-1:0]        zptr,
  input  logic                 gie,
  input  logic                 flash_busy,
  input  logic                 eeprom_busy,
  output logic                 cmd_erase,
  output logic                 cmd_write,
  output logic                 cmd_fill,
  output logic                 cmd_sig_rd,
  output logic                 cmd_lock_rd,
  output logic [ZW-PG_LSB-1:0] cmd_page,
  output logic [PG_LSB-1:0]    cmd_offs,
  output logic                 cpu_halt,
  output logic                 buf_clear,
  output logic                 ready_irq
);
  localparam int WMAX = (WIN_WR > WIN_RD) ? WIN_WR : WIN_RD;
  localparam int CW   = $clog2(WMAX + 1);
  localparam logic [7:0] KEEP_ARM   = ~(8'd1 << B_BUSY);
  localparam logic [7:0] KEEP_PLAIN = 8'd1 << B_IRQ;

  logic [7:0] ctl_q, ctl_d;
  mode_e      mode_q, mode_d, wr_mode;
  logic       op_act_q, op_seen_q, fill_pend_q, buf_clr_q;
  logic       win_open, win_last;
  logic [NK-1:0] pulse_w;

  // named internal events
  logic wr_ok, arm_evt, plain_evt, hit_evt, match_evt, expire_evt;
  logic op_done_evt, clr_cmd, fill_evt, buf_clr_d;

  assign wr_mode     = decode_mode(reg_wr_data[5:0]);
  assign wr_ok       = reg_wr_en & ~op_act_q;
  assign arm_evt     = wr_ok & reg_wr_data[B_EN];
  assign plain_evt   = wr_ok & ~reg_wr_data[B_EN];
  assign hit_evt     = win_open & (is_read(mode_q) ? ld_exec : st_exec);
  assign match_evt   = hit_evt & ~reg_wr_en;
  assign expire_evt  = win_last & ~hit_evt & ~reg_wr_en;
  assign op_done_evt = op_act_q & op_seen_q & ~flash_busy;
  assign clr_cmd     = (match_evt & ~is_flash_op(mode_q)) | expire_evt | op_done_evt;
  assign fill_evt    = match_evt & (mode_q == M_FILL);
  assign buf_clr_d   = wr_ok & reg_wr_data[B_RWW] & fill_pend_q;

  spm_window #(.CW(CW)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (arm_evt),
    .len_i  (CW'(arm_len(wr_mode, WIN_WR, WIN_RD))),
    .stop_i (match_evt | plain_evt),
    .open_o (win_open),
    .last_o (win_last)
  );

  spm_issue #(.ZW(ZW), .PG_LSB(PG_LSB)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (match_evt),
    .mode_i  (mode_q),
    .zptr_i  (zptr),
    .pulse_o (pulse_w),
    .page_o  (cmd_page),
    .offs_o  (cmd_offs)
  );

  always_comb begin
    ctl_d  = ctl_q;
    mode_d = mode_q;
    if (clr_cmd) begin
      ctl_d[B_SIG:B_EN] = '0;
      mode_d            = M_IDLE;
    end
    if (reg_wr_en) begin
      if (op_act_q) begin
        ctl_d[B_IRQ] = reg_wr_data[B_IRQ];
      end else begin
        ctl_d  = reg_wr_data & (reg_wr_data[B_EN] ? KEEP_ARM : KEEP_PLAIN);
        mode_d = wr_mode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      mode_q      <= M_IDLE;
      op_act_q    <= 1'b0;
      op_seen_q   <= 1'b0;
      fill_pend_q <= 1'b0;
      buf_clr_q   <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      mode_q    <= mode_d;
      buf_clr_q <= buf_clr_d;
      if (match_evt & is_flash_op(mode_q)) op_act_q <= 1'b1;
      else if (op_done_evt)                op_act_q <= 1'b0;
      if (op_done_evt)                     op_seen_q <= 1'b0;
      else if (op_act_q & flash_busy)      op_seen_q <= 1'b1;
      if (buf_clr_d | (op_done_evt & (mode_q == M_WRITE))) fill_pend_q <= 1'b0;
      else if (fill_evt)                                   fill_pend_q <= 1'b1;
    end
  end

  assign reg_rd_data = ctl_q;
  assign cmd_erase   = pulse_w[K_ERASE];
  assign cmd_write   = pulse_w[K_WRITE];
  assign cmd_fill    = pulse_w[K_FILL];
  assign cmd_sig_rd  = pulse_w[K_SIG];
  assign cmd_lock_rd = pulse_w[K_LOCK];
  assign cpu_halt    = op_act_q & (mode_q == M_WRITE);
  assign buf_clear   = buf_clr_q;
  assign ready_irq   = ctl_q[B_IRQ] & gie & ~ctl_q[B_EN] & ~eeprom_busy & ~op_act_q;
endmodule

// File: rtl/spm_ctl_chk.sv
module spm_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic [7:0] reg_rd_data,
  input logic [4:0] pulses,
  input logic       cpu_halt,
  input logic       ready_irq,
  input logic       buf_clear,
  input logic       match_evt,
  input logic       expire_evt
);
  // R2
  busy_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[6] == 1'b0);

  // R4
  expire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (reg_rd_data[5:0] == 6'd0) && (pulses == 5'd0));

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  // R6
  pulse_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses != 5'd0) |-> $past(match_evt));

  // R7
  halt_starts_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt) |-> pulses[1]);

  // R9
  clear_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |-> $past(reg_wr_en));

  // R10
  halt_mutes_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> !ready_irq);
endmodule

bind selfprog_ctrl spm_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_rd_data (reg_rd_data),
  .pulses      ({cmd_lock_rd, cmd_sig_rd, cmd_fill, cmd_write, cmd_erase}),
  .cpu_halt    (cpu_halt),
  .ready_irq   (ready_irq),
  .buf_clear   (buf_clear),
  .match_evt   (match_evt),
  .expire_evt  (expire_evt)
);

// File: tb/selfprog_ctrl_test.sv
module selfprog_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ZW = 16;
  localparam int PG_LSB = 7;
  localparam int WD_CYCLES = 5000;
  // pulse kinds: 0 erase, 1 write, 2 fill, 3 sig, 4 lock
  localparam int KE = 0, KW = 1, KF = 2, KS = 3, KL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0, st_exec = 1'b0, ld_exec = 1'b0;
  logic gie = 1'b0, flash_busy = 1'b0, eeprom_busy = 1'b0;
  logic [7:0] reg_wr_data = '0, reg_rd_data;
  logic [ZW-1:0] zptr = '0;
  logic cmd_erase, cmd_write, cmd_fill, cmd_sig_rd, cmd_lock_rd;
  logic [ZW-PG_LSB-1:0] cmd_page;
  logic [PG_LSB-1:0] cmd_offs;
  logic cpu_halt, buf_clear, ready_irq;

  selfprog_ctrl #(.ZW(ZW), .PG_LSB(PG_LSB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .st_exec(st_exec), .ld_exec(ld_exec), .zptr(zptr),
    .gie(gie), .flash_busy(flash_busy), .eeprom_busy(eeprom_busy),
    .cmd_erase(cmd_erase), .cmd_write(cmd_write), .cmd_fill(cmd_fill),
    .cmd_sig_rd(cmd_sig_rd), .cmd_lock_rd(cmd_lock_rd), .cmd_page(cmd_page),
    .cmd_offs(cmd_offs), .cpu_halt(cpu_halt), .buf_clear(buf_clear), .ready_irq(ready_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { int kind; int page; int offs; string tag; } exp_t;
  exp_t sb[$];
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic expect_cmd(input int kind, input int z, input string tag);
    exp_t e;
    e.kind = kind;
    e.page = z >> PG_LSB;
    e.offs = z & ((1 << PG_LSB) - 1);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic instr(input bit is_ld, input int z, input int gap);
    repeat (gap) @(negedge clk);
    zptr = ZW'(z);
    if (is_ld) ld_exec = 1'b1; else st_exec = 1'b1;
    @(negedge clk);
    ld_exec = 1'b0;
    st_exec = 1'b0;
  endtask

  task automatic rd_is(input logic [7:0] expv, input string tag);
    #1 check(reg_rd_data == expv, tag, "read-back", reg_rd_data, expv);
  endtask

  // flash controller model: busy for four cycles after each erase/write pulse
  initial begin : flash_model
    int n;
    n = 0;
    forever begin
      @(negedge clk);
      if (cmd_write | cmd_erase) begin
        flash_busy = 1'b1;
        n = 4;
      end else if (n > 0) begin
        n--;
        if (n == 0) flash_busy = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin : monitor
    logic [4:0] p;
    exp_t e;
    forever begin
      @(negedge clk);
      p = {cmd_lock_rd, cmd_sig_rd, cmd_fill, cmd_write, cmd_erase};
      if (rst_n && p != 5'd0) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11", "unexpected command pulse", p, 0);
        end else begin
          e = sb.pop_front();
          check(p == (5'd1 << e.kind), e.tag, "pulse kind", p, 1 << e.kind);
          check(cmd_page == e.page, e.tag, "page", cmd_page, e.page);
          check(cmd_offs == e.offs, e.tag, "offset", cmd_offs, e.offs);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_is(8'h00, "R1");
    check(!cpu_halt && !buf_clear && !ready_irq, "R1", "idle outputs",
          {cpu_halt, buf_clear, ready_irq}, 0);

    // R2 bit 6 read-only; R10 interrupt terms
    wr(8'hC0);
    rd_is(8'h80, "R2");
    gie = 1'b1;
    #1 check(ready_irq == 1'b1, "R10", "irq when idle", ready_irq, 1);
    eeprom_busy = 1'b1;
    #1 check(ready_irq == 1'b0, "R10", "irq masked by eeprom", ready_irq, 0);
    eeprom_busy = 1'b0;

    // R3 arm read-back, R6 erase at last window edge
    wr(8'h83);
    rd_is(8'h83, "R3");
    check(ready_irq == 1'b0, "R10", "irq masked while armed", ready_irq, 0);
    expect_cmd(KE, 16'h1234, "R6");
    instr(1'b0, 16'h1234, 3);
    #1 check(cpu_halt == 1'b0, "R7", "no halt for erase", cpu_halt, 0);
    rd_is(8'h83, "R6");
    repeat (8) @(negedge clk);
    rd_is(8'h80, "R6");

    // R6 load ignored in store window; R4 expiry
    wr(8'h85);
    instr(1'b1, 0, 0);
    rd_is(8'h85, "R6");
    instr(1'b0, 0, 3);
    rd_is(8'h80, "R4");

    // R7 page write with halt, writes during op
    wr(8'h85);
    expect_cmd(KW, 16'h0080, "R7");
    instr(1'b0, 16'h0080, 3);
    #1 check(cpu_halt == 1'b1, "R7", "halt during write", cpu_halt, 1);
    wr(8'h01);
    rd_is(8'h05, "R7");
    wr(8'h81);
    rd_is(8'h85, "R7");
    repeat (8) @(negedge clk);
    #1 check(cpu_halt == 1'b0, "R7", "halt released", cpu_halt, 0);
    rd_is(8'h80, "R7");

    // R8 signature read, store in load window ignored
    wr(8'hA1);
    instr(1'b0, 0, 0);
    expect_cmd(KS, 2, "R8");
    instr(1'b1, 2, 1);
    rd_is(8'h80, "R8");

    // R5 load on 4th edge is too late
    wr(8'hA1);
    instr(1'b1, 0, 3);
    rd_is(8'h80, "R5");

    // R8 lock read with Z bit 0 = 1 (fuse select)
    wr(8'h89);
    expect_cmd(KL, 1, "R8");
    instr(1'b1, 1, 2);
    #1 check(cmd_offs[0] == 1'b1, "R8", "lock select", cmd_offs[0], 1);

    // R8 fill then R9 buffer clear
    wr(8'h81);
    expect_cmd(KF, 16'h0046, "R8");
    instr(1'b0, 16'h0046, 1);
    wr(8'h90);
    #1 check(buf_clear == 1'b1, "R9", "buffer clear pulse", buf_clear, 1);
    rd_is(8'h80, "R3");
    @(negedge clk);
    #1 check(buf_clear == 1'b0, "R9", "buffer clear single cycle", buf_clear, 0);
    wr(8'h90);
    #1 check(buf_clear == 1'b0, "R9", "no clear without pending fill", buf_clear, 0);

    // R11 priority and one pulse per window
    wr(8'h87);
    expect_cmd(KE, 16'h0300, "R11");
    instr(1'b0, 16'h0300, 0);
    instr(1'b0, 16'h0300, 0);
    repeat (8) @(negedge clk);
    rd_is(8'h80, "R11");

    // R3 disarm write cancels window
    wr(8'h85);
    wr(8'h80);
    instr(1'b0, 0, 0);
    rd_is(8'h80, "R3");

    // R4 re-arm restarts window
    wr(8'h85);
    repeat (2) @(negedge clk);
    wr(8'h85);
    expect_cmd(KW, 16'h0100, "R4");
    instr(1'b0, 16'h0100, 3);
    repeat (8) @(negedge clk);
    rd_is(8'h80, "R4");

    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R6", "missing command pulses", sb.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule